// File: doc/BRIEF.md
# Single-wire bus session power sequencer

This block decides when a slave on a single-wire, open-drain serial bus is powered and when it is not. It runs from a free-running clock of about 532 kHz. A long low "break" from the host wakes it. Low pulses that are too short to count as a break are ignored. After a valid break the block returns a break of its own after a fixed delay, then opens a session in which a separate frame decoder may work.

The session ends in one of two ways. The frame decoder may report the two-bit sleep opcode, or the bus may stay idle for about one second. Either way the regulator enable stays high for a short guard time before it drops. A soft-reset strobe during a session makes the block answer with a fresh break and restart the session.

The bus line is only ever pulled low. While the block drives its own break, it is blind to the line, and it stays blind for the few cycles the synchronizer needs to deliver its own release. That release is therefore never taken for host activity.

Top module: `swb_pwr_seq`

## Requirements
- R1: After reset, bus_pull_o, reg_en_o and session_o are all low and the block is asleep.
- R2: A host low on bus_i that lasts at least DEGLITCH_CYC clock cycles wakes the block. reg_en_o rises DEGLITCH_CYC+2 cycles after the host lowers the line. A low lasting DEGLITCH_CYC-1 cycles or less leaves every output low.
- R3: After a wake, bus_pull_o rises ECHO_DELAY_CYC+2 cycles after the host lowered the line. It stays high for exactly BREAK_LEN_CYC cycles.
- R4: session_o rises in the same cycle that the returned break ends. bus_pull_o is never high while session_o is high.
- R5: During a session, a strobe on opcode_vld_i with opcode_i equal to 2'b11 drops session_o in the next cycle. reg_en_o then stays high for exactly SLEEP_WAIT_CYC more cycles. A strobe with any other opcode value has no effect.
- R6: During a session, if the synchronized bus shows no transition for IDLE_TIMEOUT_CYC cycles, session_o falls and the sleep guard of R5 follows. Any host transition restarts the count.
- R7: The rising edge of the block's own returned break is not counted as bus activity. With a quiet host, a session lasts exactly IDLE_TIMEOUT_CYC cycles.
- R8: During a session, a soft_rst_i strobe drops session_o in the next cycle. It takes priority over a sleep opcode in the same cycle. bus_pull_o rises SRST_DELAY_CYC+1 cycles after the strobe cycle and lasts BREAK_LEN_CYC cycles. A new session then opens with the idle count restarted.
- R9: Sleep opcodes and soft_rst_i are ignored while the block is asleep or validating a wake. The wake timing of R2 and R3 is unchanged by them.
- R10: bus_pull_o is the only drive onto the line, and it is high only while reg_en_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running bus reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_i | input | 1 | Raw bus line level, asynchronous |
| opcode_vld_i | input | 1 | One-cycle strobe from the frame decoder |
| opcode_i | input | 2 | Decoded opcode, 2'b11 requests sleep |
| soft_rst_i | input | 1 | One-cycle soft-reset request |
| bus_pull_o | output | 1 | Open-drain pull-low enable |
| reg_en_o | output | 1 | Regulator enable |
| session_o | output | 1 | Session active |

## Verification
The bench sends a host low that is one cycle shorter than the deglitch window, and one that is exactly as long. A filter that is off by one cycle either wakes on the first or misses the second. With a quiet host, it measures the session length against the idle limit. A design that counts its own break release as activity runs three cycles long. It also checks that a later host pulse pushes the timeout out. It times the sleep guard, the soft-reset echo and the priority of soft reset over sleep cycle by cycle. It also sends strobes during sleep and during wake validation, where a design that obeyed them would drive the line early or wake without a break.

// File: rtl/swb_pwr_pkg.sv
package swb_pwr_pkg;

  typedef enum logic [2:0] {
    ST_SLEEP,
    ST_WAKE_FILT,
    ST_BRK_WAIT,
    ST_BRK_DRIVE,
    ST_ACTIVE,
    ST_SLEEP_WAIT
  } pwr_state_e;

  localparam logic [1:0] OP_SLEEP = 2'b11;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/swb_pwr_sync.sv
module swb_pwr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/swb_pwr_edge.sv
module swb_pwr_edge #(
  parameter int unsigned HOLD = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic mask_i,
  output logic fall_o,
  output logic toggle_o
);

  localparam int unsigned HW = $clog2(HOLD + 1);
  localparam logic [HW-1:0] HOLD_V = HW'(HOLD);

  logic          level_q;
  logic [HW-1:0] hold_q;
  logic          blind;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b1;
      hold_q  <= '0;
    end else begin
      level_q <= level_i;
      if (mask_i)              hold_q <= HOLD_V;
      else if (hold_q != '0)   hold_q <= hold_q - HW'(1);
    end
  end

  // stay blind until own release has crossed the synchronizer
  assign blind    = mask_i | (hold_q != '0);
  assign fall_o   = !blind & level_q & !level_i;
  assign toggle_o = !blind & (level_q ^ level_i);

endmodule

// File: rtl/swb_pwr_idle.sv
module swb_pwr_idle #(
  parameter int unsigned LIMIT = 532000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic reload_i,
  output logic expire_o
);

  localparam int unsigned IW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [IW-1:0] LAST = IW'(LIMIT - 1);

  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || reload_i) cnt_q <= '0;
    else if (cnt_q != LAST)      cnt_q <= cnt_q + IW'(1);
  end

  assign expire_o = run_i & !reload_i & (cnt_q == LAST);

endmodule

// File: rtl/swb_pwr_seq.sv
module swb_pwr_seq
  import swb_pwr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES      = 2,
  parameter int unsigned DEGLITCH_CYC     = 8,
  parameter int unsigned ECHO_DELAY_CYC   = 32,
  parameter int unsigned BREAK_LEN_CYC    = 16,
  parameter int unsigned SLEEP_WAIT_CYC   = 3,
  parameter int unsigned IDLE_TIMEOUT_CYC = 532000,
  parameter int unsigned SRST_DELAY_CYC   = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_i,
  input  logic       opcode_vld_i,
  input  logic [1:0] opcode_i,
  input  logic       soft_rst_i,
  output logic       bus_pull_o,
  output logic       reg_en_o,
  output logic       session_o
);

  localparam int unsigned CNT_MAX = max3(ECHO_DELAY_CYC, BREAK_LEN_CYC, SLEEP_WAIT_CYC);
  localparam int unsigned SW      = $clog2(CNT_MAX + 1);
  localparam logic [SW-1:0] DEG_LAST  = SW'(DEGLITCH_CYC - 1);
  localparam logic [SW-1:0] ECHO_LAST = SW'(ECHO_DELAY_CYC - 1);
  localparam logic [SW-1:0] BRK_LAST  = SW'(BREAK_LEN_CYC - 1);
  localparam logic [SW-1:0] SLW_LAST  = SW'(SLEEP_WAIT_CYC - 1);
  localparam logic [SW-1:0] SRST_LOAD = SW'(ECHO_DELAY_CYC - SRST_DELAY_CYC);

  pwr_state_e    state_q, state_d;
  logic [SW-1:0] seq_q, seq_d;
  logic          bus_s;
  logic          fall, toggle;
  logic          idle_expire;
  logic          sleep_req;
  logic          pull_q, reg_q, sess_q;

  swb_pwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bus_i),
    .q_o   (bus_s)
  );

  swb_pwr_edge #(.HOLD(SYNC_STAGES + 1)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (bus_s),
    .mask_i  (pull_q),
    .fall_o  (fall),
    .toggle_o(toggle)
  );

  swb_pwr_idle #(.LIMIT(IDLE_TIMEOUT_CYC)) u_idle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (state_q == ST_ACTIVE),
    .reload_i(toggle),
    .expire_o(idle_expire)
  );

  assign sleep_req = opcode_vld_i && (opcode_i == OP_SLEEP);

  always_comb begin
    state_d = state_q;
    seq_d   = seq_q + SW'(1);
    unique case (state_q)
      ST_SLEEP: begin
        seq_d = '0;
        if (fall) begin
          state_d = ST_WAKE_FILT;
          seq_d   = SW'(1);
        end
      end
      ST_WAKE_FILT: begin
        if (bus_s) begin
          state_d = ST_SLEEP;
          seq_d   = '0;
        end else if (seq_q == DEG_LAST) begin
          state_d = ST_BRK_WAIT;
        end
      end
      ST_BRK_WAIT: begin
        if (seq_q == ECHO_LAST) begin
          state_d = ST_BRK_DRIVE;
          seq_d   = '0;
        end
      end
      ST_BRK_DRIVE: begin
        if (seq_q == BRK_LAST) begin
          state_d = ST_ACTIVE;
          seq_d   = '0;
        end
      end
      ST_ACTIVE: begin
        seq_d = '0;
        if (soft_rst_i) begin
          state_d = ST_BRK_WAIT;
          seq_d   = SRST_LOAD;
        end else if (sleep_req || idle_expire) begin
          state_d = ST_SLEEP_WAIT;
        end
      end
      ST_SLEEP_WAIT: begin
        if (seq_q == SLW_LAST) begin
          state_d = ST_SLEEP;
          seq_d   = '0;
        end
      end
      default: begin
        state_d = ST_SLEEP;
        seq_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SLEEP;
      seq_q   <= '0;
      pull_q  <= 1'b0;
      reg_q   <= 1'b0;
      sess_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      seq_q   <= seq_d;
      pull_q  <= (state_d == ST_BRK_DRIVE);
      reg_q   <= (state_d inside {ST_BRK_WAIT, ST_BRK_DRIVE, ST_ACTIVE, ST_SLEEP_WAIT});
      sess_q  <= (state_d == ST_ACTIVE);
    end
  end

  assign bus_pull_o = pull_q;
  assign reg_en_o   = reg_q;
  assign session_o  = sess_q;

endmodule

// File: rtl/swb_pwr_seq_chk.sv
module swb_pwr_seq_chk #(
  parameter int unsigned BREAK_LEN_CYC  = 16,
  parameter int unsigned SLEEP_WAIT_CYC = 3
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       opcode_vld_i,
  input logic [1:0] opcode_i,
  input logic       soft_rst_i,
  input logic       bus_pull_o,
  input logic       reg_en_o,
  input logic       session_o
);

  logic [15:0] pull_run_q;
  logic [15:0] off_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pull_run_q <= '0;
      off_run_q  <= '0;
    end else begin
      if (!bus_pull_o)              pull_run_q <= '0;
      else if (pull_run_q != '1)    pull_run_q <= pull_run_q + 16'd1;
      if (session_o)                off_run_q  <= '0;
      else if (off_run_q != '1)     off_run_q  <= off_run_q + 16'd1;
    end
  end

  p_pull_needs_reg_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_pull_o |-> reg_en_o);

  p_break_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_pull_o) |-> pull_run_q == 16'(BREAK_LEN_CYC));

  p_quiet_in_session_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    session_o |-> !bus_pull_o);

  p_sleep_guard_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reg_en_o) |-> off_run_q == 16'(SLEEP_WAIT_CYC));

  p_sleep_cmd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (session_o && opcode_vld_i && opcode_i == 2'b11 && !soft_rst_i)
      |=> (!session_o && reg_en_o && !bus_pull_o));

  p_srst_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (session_o && soft_rst_i) |=> (!session_o && reg_en_o));

  p_asleep_no_drive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_en_o |=> !bus_pull_o);

endmodule

bind swb_pwr_seq swb_pwr_seq_chk #(
  .BREAK_LEN_CYC (BREAK_LEN_CYC),
  .SLEEP_WAIT_CYC(SLEEP_WAIT_CYC)
) u_chk (.*);

// File: tb/swb_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module swb_pwr_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;
  localparam int D = 8;
  localparam int E = 32;
  localparam int B = 16;
  localparam int W = 3;
  localparam int T = 200;
  localparam int S = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       host_lvl = 1'b1;
  logic       opcode_vld = 1'b0;
  logic [1:0] opcode = 2'b00;
  logic       soft_rst = 1'b0;
  logic       bus_line;
  logic       pull, reg_en, session;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_line = host_lvl & ~pull;

  swb_pwr_seq #(
    .SYNC_STAGES(SYNC), .DEGLITCH_CYC(D), .ECHO_DELAY_CYC(E), .BREAK_LEN_CYC(B),
    .SLEEP_WAIT_CYC(W), .IDLE_TIMEOUT_CYC(T), .SRST_DELAY_CYC(S)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bus_i(bus_line), .opcode_vld_i(opcode_vld),
    .opcode_i(opcode), .soft_rst_i(soft_rst), .bus_pull_o(pull),
    .reg_en_o(reg_en), .session_o(session)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // phases: 0 asleep, 1 filtering, 2 waiting to echo, 3 echoing, 4 session, 5 guard
  int m_ph, m_n, m_idle, m_blind;
  bit m_prev;
  bit m_pipe[$];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_n = 0; m_idle = 0; m_blind = 0; m_prev = 1;
      m_pipe = {};
      for (int k = 0; k < SYNC; k++) m_pipe.push_back(1'b1);
    end else begin
      bit lvl, blind, fell, moved, line;
      lvl   = m_pipe[SYNC-1];
      blind = (m_ph == 3) || (m_blind > 0);
      fell  = !blind && m_prev && !lvl;
      moved = !blind && (m_prev != lvl);
      line  = host_lvl && (m_ph != 3);
      m_blind = (m_ph == 3) ? SYNC + 1 : ((m_blind > 0) ? m_blind - 1 : 0);
      case (m_ph)
        0: if (fell) begin m_ph = 1; m_n = 1; end
        1: if (lvl) m_ph = 0;
           else begin m_n++; if (m_n == D) m_ph = 2; end
        2: begin m_n++; if (m_n == E) begin m_ph = 3; m_n = 0; end end
        3: begin m_n++; if (m_n == B) begin m_ph = 4; m_idle = 0; end end
        4: if (soft_rst) begin m_ph = 2; m_n = E - S; end
           else if (opcode_vld && opcode == 2'b11) begin m_ph = 5; m_n = 0; end
           else if (moved) m_idle = 0;
           else begin m_idle++; if (m_idle == T) begin m_ph = 5; m_n = 0; end end
        default: begin m_n++; if (m_n == W) m_ph = 0; end
      endcase
      m_prev = lvl;
      m_pipe.push_front(line);
      void'(m_pipe.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      check("R3", "pull vs model", int'(pull), int'(m_ph == 3));
      check("R2", "reg_en vs model", int'(reg_en), int'(m_ph >= 2));
      check("R4", "session vs model", int'(session), int'(m_ph == 4));
      if (pull) check("R10", "pull without regulator", int'(reg_en), 1);
    end
  end

  // host break of len cycles; optional strobe at cycle strobe_at; returns first-seen times
  task automatic wake(input int len, input int strobe_at,
                      output int t_reg, output int t_pull, output int t_pend, output int t_sess);
    t_reg = -1; t_pull = -1; t_pend = -1; t_sess = -1;
    host_lvl = 1'b0;
    for (int i = 1; i <= E + B + 20; i++) begin
      @(negedge clk);
      soft_rst = 1'b0; opcode_vld = 1'b0;
      if (reg_en && t_reg < 0) t_reg = i;
      if (pull && t_pull < 0) t_pull = i;
      if (!pull && t_pull > 0 && t_pend < 0) t_pend = i;
      if (session && t_sess < 0) t_sess = i;
      if (i == len) host_lvl = 1'b1;
      if (i == strobe_at) begin soft_rst = 1'b1; opcode_vld = 1'b1; opcode = 2'b11; end
      if (t_sess > 0) break;
    end
  endtask

  task automatic session_len(output int len, output int guard);
    len = 1; guard = 0;
    for (int i = 0; i < T + 50; i++) begin
      @(negedge clk);
      if (!session) break;
      len++;
    end
    for (int i = 0; i < 20; i++) begin
      if (!reg_en) break;
      guard++;
      @(negedge clk);
    end
  endtask

  initial begin
    int tr, tp, te, ts, len, grd;
    repeat (3) @(negedge clk);
    check("R1", "pull after reset", int'(pull), 0);
    check("R1", "reg_en after reset", int'(reg_en), 0);
    check("R1", "session after reset", int'(session), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // glitch one cycle short of the window
    host_lvl = 1'b0;
    repeat (D - 1) @(negedge clk);
    host_lvl = 1'b1;
    repeat (20) @(negedge clk);
    check("R2", "reg_en after short low", int'(reg_en), 0);

    // strobes while asleep
    soft_rst = 1'b1; opcode_vld = 1'b1; opcode = 2'b11;
    @(negedge clk);
    soft_rst = 1'b0; opcode_vld = 1'b0;
    repeat (40) @(negedge clk);
    check("R9", "pull after strobes in sleep", int'(pull), 0);
    check("R9", "reg_en after strobes in sleep", int'(reg_en), 0);

    // boundary-length break, quiet host -> timeout
    wake(D, -1, tr, tp, te, ts);
    check("R2", "wake latency", tr, D + 2);
    check("R3", "echo latency", tp, E + 2);
    check("R3", "echo end", te, E + 2 + B);
    check("R4", "session start", ts, E + 2 + B);
    session_len(len, grd);
    check("R7", "quiet session length", len, T);
    check("R6", "guard after timeout", grd, W);
    repeat (10) @(negedge clk);

    // strobes during wake validation are ignored
    wake(12, D + 4, tr, tp, te, ts);
    check("R9", "echo latency with strobe in wake", tp, E + 2);
    check("R9", "session start with strobe in wake", ts, E + 2 + B);
    repeat (100) @(negedge clk);
    host_lvl = 1'b0;
    repeat (2) @(negedge clk);
    host_lvl = 1'b1;
    repeat (T - 102) @(negedge clk);
    check("R6", "session held after host activity", int'(session), 1);

    // non-sleep opcode ignored
    opcode_vld = 1'b1; opcode = 2'b10;
    @(negedge clk);
    opcode_vld = 1'b0;
    check("R5", "session after opcode 2'b10", int'(session), 1);
    opcode_vld = 1'b1; opcode = 2'b11;
    @(negedge clk);
    opcode_vld = 1'b0;
    check("R5", "session after sleep opcode", int'(session), 0);
    check("R5", "reg_en right after sleep opcode", int'(reg_en), 1);
    repeat (W - 1) @(negedge clk);
    check("R5", "reg_en at end of guard", int'(reg_en), 1);
    @(negedge clk);
    check("R5", "reg_en after guard", int'(reg_en), 0);
    repeat (10) @(negedge clk);

    // soft reset beats sleep opcode
    wake(12, -1, tr, tp, te, ts);
    repeat (5) @(negedge clk);
    soft_rst = 1'b1; opcode_vld = 1'b1; opcode = 2'b11;
    @(negedge clk);
    soft_rst = 1'b0; opcode_vld = 1'b0;
    check("R8", "session after soft reset", int'(session), 0);
    check("R8", "reg_en after soft reset", int'(reg_en), 1);
    repeat (S - 1) @(negedge clk);
    check("R8", "pull before echo", int'(pull), 0);
    @(negedge clk);
    check("R8", "pull at echo", int'(pull), 1);
    repeat (B - 1) @(negedge clk);
    check("R8", "pull at echo end", int'(pull), 1);
    @(negedge clk);
    check("R8", "pull after echo", int'(pull), 0);
    check("R8", "session reopened", int'(session), 1);
    session_len(len, grd);
    check("R8", "session length after soft reset", len, T);
    repeat (10) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule